// File: doc/BRIEF.md
# Multi-View Vector Register File

This block holds thirty-two 128-bit vector registers for a SIMD datapath. Every register can be accessed in three ways: as a scalar of 8, 16, 32, 64 or 128 bits taken from its low end, as a vector whose lane layout is chosen by an arrangement code, or as a single lane picked out by a lane index. Two combinational read ports and one write port serve the execution pipeline. All three can target the same register in the same cycle.

A separate group-transfer port moves one to four registers over a 128-bit bus, one register per clock. The register numbers in a group wrap around modulo 32. This port serves multi-register load and store sequences. A group write and the ordinary write port may be active in the same cycle. When both target the same register, the group write is the one that takes effect.

Top module: `vrf_multiview`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all 32 registers are cleared to zero and the group sequencer returns to idle (busy and done low).
- R2: A scalar read (kind 0) returns the low bits of the register selected by the view code, zero-extended to 128 bits. The view codes are: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits, 4 = 128 bits. Codes 5 to 7 behave like code 4.
- R3: A scalar write (write kind 0) stores the low bits of the write data covered by the view code, using the same code table as R2. All register bits above the view are cleared.
- R4: The arrangement codes are: 0 = 2x64, 1 = 4x32, 2 = 8x16 and 3 = 16x8, all over 128 bits; 4 = 1x64, 5 = 2x32, 6 = 4x16 and 7 = 8x8, all over 64 bits. A vector access (read kind 1 or write kind 1) with a code whose bit 2 is set uses only bits [63:0]. Such a read returns zero in bits [127:64], and such a write clears them. Codes 0 to 3 move all 128 bits.
- R5: An element read (read kind 2 or 3) uses the view code as the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64, 4 to 7 = 128 bits). Lane k of width w returns register bits [k*w+w-1 : k*w], zero-extended. For example, lane 6 at 16 bits returns bits [111:96].
- R6: An element read whose lane index is not less than 128/w sets that port's `lane_err` and returns zero data. For every other read, `lane_err` is low.
- R7: The two read ports work independently and may name the same register at the same time.
- R8: A read of the register that is being written in the same cycle returns the old contents. The new value is visible from the next cycle on.
- R9: A `grp_start` seen while idle latches the first register, the direction (`grp_write` = 1 writes registers from `grp_wdata`) and `grp_count`, which holds the number of registers minus one. `grp_busy` is high from the next cycle on. Each busy cycle handles one register.
- R10: A group that starts at register t handles t, (t+1) mod 32, (t+2) mod 32 and (t+3) mod 32, in that order.
- R11: In the cycle after the last register's edge, `grp_busy` is low and `grp_done` is high for exactly one cycle. A `grp_start` that arrives while busy is ignored.
- R12: When a group write beat and the write port target the same register in the same cycle, the group data is stored. A write-port write to any other register in that cycle still takes effect.
- R13: During a group read beat, `grp_rdata` shows the current register of the group. At all other times `grp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_idx | input | 5 | Read port 0 register number |
| rd0_kind | input | 2 | Read port 0 access kind: 0 scalar, 1 vector, 2/3 element |
| rd0_sel | input | 3 | Read port 0 view code or arrangement code |
| rd0_lane | input | 4 | Read port 0 lane index for element reads |
| rd0_data | output | 128 | Read port 0 data |
| rd0_lane_err | output | 1 | Read port 0 lane index out of range |
| rd1_idx | input | 5 | Read port 1 register number |
| rd1_kind | input | 2 | Read port 1 access kind |
| rd1_sel | input | 3 | Read port 1 view or arrangement code |
| rd1_lane | input | 4 | Read port 1 lane index |
| rd1_data | output | 128 | Read port 1 data |
| rd1_lane_err | output | 1 | Read port 1 lane index out of range |
| wr_en | input | 1 | Write port enable |
| wr_kind | input | 1 | Write kind: 0 scalar view, 1 vector arrangement |
| wr_sel | input | 3 | Write view code or arrangement code |
| wr_idx | input | 5 | Write register number |
| wr_data | input | 128 | Write data |
| grp_start | input | 1 | Start a group transfer |
| grp_write | input | 1 | Group direction: 1 write registers, 0 read registers |
| grp_first | input | 5 | First register of the group |
| grp_count | input | 2 | Number of registers minus one |
| grp_wdata | input | 128 | Group write data, one register per busy cycle |
| grp_rdata | output | 128 | Group read data |
| grp_busy | output | 1 | Group transfer running |
| grp_done | output | 1 | One-cycle pulse after the last register |

## Verification
The write-visibility property only covers full-width vector writes made while no group is running. This is because a group beat to the same register would win under R12. The stimulus therefore checks collisions separately, inside group transfers, and keeps every other write-port write outside group activity. The property linking `grp_start` to `grp_busy` assumes that a start pulse is not cancelled by reset in the next cycle. The bench only asserts reset while the sequencer is idle. The sweeps cover every register, every view and arrangement code, and every lane index from 0 to 15 at each lane width on both ports. Group transfers use every length, with start points near 31 so that the groups wrap.

// File: rtl/vrf_pkg.sv
`timescale 1ns/1ps
// Package vrf_pkg: shared widths and access-code definitions for the
// multi-view vector register file. Assumes a fixed 128-bit register width.
package vrf_pkg;
    localparam int VRF_DW   = 128;
    localparam int VRF_HALF = VRF_DW / 2;

    // Scalar view / lane width codes
    localparam logic [2:0] VW_8   = 3'd0;
    localparam logic [2:0] VW_16  = 3'd1;
    localparam logic [2:0] VW_32  = 3'd2;
    localparam logic [2:0] VW_64  = 3'd3;
    localparam logic [2:0] VW_128 = 3'd4;

    // Read access kinds
    typedef enum logic [1:0] {
        RK_SCALAR = 2'd0,
        RK_VECTOR = 2'd1,
        RK_ELEM   = 2'd2,
        RK_ELEM_B = 2'd3
    } rd_kind_e;

    // Keep the low bits covered by a scalar view; clear the rest.
    function automatic logic [VRF_DW-1:0] view_trim(input logic [2:0] sel,
                                                    input logic [VRF_DW-1:0] v);
        logic [VRF_DW-1:0] r;
        r = '0;
        case (sel)
            VW_8:    r[7:0]  = v[7:0];
            VW_16:   r[15:0] = v[15:0];
            VW_32:   r[31:0] = v[31:0];
            VW_64:   r[63:0] = v[63:0];
            default: r       = v;
        endcase
        return r;
    endfunction

    // Keep the bits an arrangement covers: bit 2 set means the low half only.
    function automatic logic [VRF_DW-1:0] arr_trim(input logic [2:0] sel,
                                                   input logic [VRF_DW-1:0] v);
        logic [VRF_DW-1:0] r;
        r = v;
        if (sel[2]) begin
            r[VRF_DW-1:VRF_HALF] = '0;
        end
        return r;
    endfunction
endpackage

// File: rtl/vrf_write_shaper.sv
`timescale 1ns/1ps
// Module vrf_write_shaper: forms the full 128-bit value stored by the write
// port. Scalar views and 64-bit arrangements zero the uncovered upper bits.
// Assumes kind 0 = scalar view, kind 1 = vector arrangement.
module vrf_write_shaper
    import vrf_pkg::*;
(
    input  logic              kind,
    input  logic [2:0]        sel,
    input  logic [VRF_DW-1:0] din,
    output logic [VRF_DW-1:0] dout
);
    // Select the trimming rule for the access kind.
    always_comb begin
        if (kind) begin
            dout = arr_trim(sel, din);
        end else begin
            dout = view_trim(sel, din);
        end
    end
endmodule

// File: rtl/vrf_read_port.sv
`timescale 1ns/1ps
// Module vrf_read_port: formats one register's contents according to a
// scalar view, a lane arrangement or a single indexed lane. Purely
// combinational; an out-of-range lane gives zero data and an error flag.
module vrf_read_port
    import vrf_pkg::*;
(
    input  logic [VRF_DW-1:0] reg_val,
    input  logic [1:0]        kind,
    input  logic [2:0]        sel,
    input  logic [3:0]        lane,
    output logic [VRF_DW-1:0] data,
    output logic              lane_err
);
    logic [VRF_DW-1:0] elem_val;
    logic              elem_bad;

    // Pick one lane of the width named by the view code.
    always_comb begin
        elem_val = '0;
        elem_bad = 1'b0;
        case (sel)
            VW_8: begin
                elem_val[7:0] = reg_val[{lane, 3'b000} +: 8];
            end
            VW_16: begin
                if (lane[3]) elem_bad = 1'b1;
                else         elem_val[15:0] = reg_val[{lane[2:0], 4'b0000} +: 16];
            end
            VW_32: begin
                if (lane[3:2] != 2'b00) elem_bad = 1'b1;
                else                    elem_val[31:0] = reg_val[{lane[1:0], 5'b00000} +: 32];
            end
            VW_64: begin
                if (lane[3:1] != 3'b000) elem_bad = 1'b1;
                else                     elem_val[63:0] = reg_val[{lane[0], 6'b000000} +: 64];
            end
            default: begin
                if (lane != 4'd0) elem_bad = 1'b1;
                else              elem_val = reg_val;
            end
        endcase
    end

    // Choose between scalar, vector and element formatting.
    always_comb begin
        data     = '0;
        lane_err = 1'b0;
        if (kind[1]) begin
            lane_err = elem_bad;
            data     = elem_bad ? '0 : elem_val;
        end else if (kind[0]) begin
            data = arr_trim(sel, reg_val);
        end else begin
            data = view_trim(sel, reg_val);
        end
    end
endmodule

// File: rtl/vrf_group_seq.sv
`timescale 1ns/1ps
// Module vrf_group_seq: steps through 1 to GMAX consecutive registers, one
// per cycle, wrapping the register number modulo NREG. Assumes NREG is a
// power of two so the index counter wraps on its own.
module vrf_group_seq #(
    parameter int NREG = 32,
    parameter int GMAX = 4,
    localparam int IW = $clog2(NREG),
    localparam int CW = (GMAX > 1) ? $clog2(GMAX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          write,
    input  logic [IW-1:0] first,
    input  logic [CW-1:0] count,
    output logic          busy,
    output logic          done,
    output logic          wmode,
    output logic [IW-1:0] cur
);
    logic [CW-1:0] left_q;

    // Latch a new group when idle, then advance one register per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            wmode  <= 1'b0;
            cur    <= '0;
            left_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    wmode  <= write;
                    cur    <= first;
                    left_q <= count;
                end
            end else begin
                cur <= cur + 1'b1;
                if (left_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    left_q <= left_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vrf_multiview.sv
`timescale 1ns/1ps
// Module vrf_multiview: NREG x 128-bit vector register file with two
// multi-view read ports, one shaped write port and a group-transfer port.
// Reads are combinational from the storage flops, so a same-cycle write is
// seen one cycle later. A group write beat has priority over the write port.
module vrf_multiview
    import vrf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int GMAX = 4,
    localparam int IW = $clog2(NREG),
    localparam int CW = (GMAX > 1) ? $clog2(GMAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     rd0_idx,
    input  logic [1:0]        rd0_kind,
    input  logic [2:0]        rd0_sel,
    input  logic [3:0]        rd0_lane,
    output logic [VRF_DW-1:0] rd0_data,
    output logic              rd0_lane_err,
    input  logic [IW-1:0]     rd1_idx,
    input  logic [1:0]        rd1_kind,
    input  logic [2:0]        rd1_sel,
    input  logic [3:0]        rd1_lane,
    output logic [VRF_DW-1:0] rd1_data,
    output logic              rd1_lane_err,
    input  logic              wr_en,
    input  logic              wr_kind,
    input  logic [2:0]        wr_sel,
    input  logic [IW-1:0]     wr_idx,
    input  logic [VRF_DW-1:0] wr_data,
    input  logic              grp_start,
    input  logic              grp_write,
    input  logic [IW-1:0]     grp_first,
    input  logic [CW-1:0]     grp_count,
    input  logic [VRF_DW-1:0] grp_wdata,
    output logic [VRF_DW-1:0] grp_rdata,
    output logic              grp_busy,
    output logic              grp_done
);
    logic [VRF_DW-1:0] regs [NREG];
    logic [VRF_DW-1:0] wr_shaped;
    logic              g_wmode;
    logic [IW-1:0]     g_cur;
    logic              g_we;

    vrf_write_shaper u_shape (
        .kind (wr_kind),
        .sel  (wr_sel),
        .din  (wr_data),
        .dout (wr_shaped)
    );

    vrf_group_seq #(.NREG(NREG), .GMAX(GMAX)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (grp_start),
        .write (grp_write),
        .first (grp_first),
        .count (grp_count),
        .busy  (grp_busy),
        .done  (grp_done),
        .wmode (g_wmode),
        .cur   (g_cur)
    );

    assign g_we = grp_busy && g_wmode;

    // One storage word per register; the group beat wins over the write port.
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (g_we && (g_cur == IW'(gi))) begin
                regs[gi] <= grp_wdata;
            end else if (wr_en && (wr_idx == IW'(gi))) begin
                regs[gi] <= wr_shaped;
            end
        end
    end

    vrf_read_port u_rd0 (
        .reg_val  (regs[rd0_idx]),
        .kind     (rd0_kind),
        .sel      (rd0_sel),
        .lane     (rd0_lane),
        .data     (rd0_data),
        .lane_err (rd0_lane_err)
    );

    vrf_read_port u_rd1 (
        .reg_val  (regs[rd1_idx]),
        .kind     (rd1_kind),
        .sel      (rd1_sel),
        .lane     (rd1_lane),
        .data     (rd1_data),
        .lane_err (rd1_lane_err)
    );

    // Drive the group bus only during read beats.
    always_comb begin
        grp_rdata = (grp_busy && !g_wmode) ? regs[g_cur] : '0;
    end
endmodule

// File: rtl/vrf_multiview_chk.sv
`timescale 1ns/1ps
// Module vrf_multiview_chk: port-level properties of vrf_multiview, bound
// to every instance of the top module.
module vrf_multiview_chk
    import vrf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        rd0_idx,
    input logic [1:0]        rd0_kind,
    input logic [2:0]        rd0_sel,
    input logic [VRF_DW-1:0] rd0_data,
    input logic              rd0_lane_err,
    input logic [VRF_DW-1:0] rd1_data,
    input logic              rd1_lane_err,
    input logic              wr_en,
    input logic              wr_kind,
    input logic [2:0]        wr_sel,
    input logic [4:0]        wr_idx,
    input logic [VRF_DW-1:0] wr_data,
    input logic              grp_start,
    input logic              grp_busy,
    input logic              grp_done
);
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd0_data == '0 && rd1_data == '0 && !grp_busy));

    assert_byte_view_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_kind == 2'd0 && rd0_sel == 3'd0) |-> rd0_data[VRF_DW-1:8] == '0);

    assert_half_arr_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_kind == 2'd1 && rd0_sel[2]) |-> rd0_data[VRF_DW-1:VRF_HALF] == '0);

    assert_lane_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_lane_err |-> rd0_data == '0) and (rd1_lane_err |-> rd1_data == '0));

    assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en && wr_kind && wr_sel == 3'd0 && !grp_busy)
         && rd0_kind == 2'd0 && rd0_sel == 3'd4 && rd0_idx == $past(wr_idx))
        |-> rd0_data == $past(wr_data));

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_start && !grp_busy) |=> grp_busy);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grp_busy) |-> grp_done);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> !grp_done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |-> !grp_busy);
endmodule

bind vrf_multiview vrf_multiview_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd0_idx      (rd0_idx),
    .rd0_kind     (rd0_kind),
    .rd0_sel      (rd0_sel),
    .rd0_data     (rd0_data),
    .rd0_lane_err (rd0_lane_err),
    .rd1_data     (rd1_data),
    .rd1_lane_err (rd1_lane_err),
    .wr_en        (wr_en),
    .wr_kind      (wr_kind),
    .wr_sel       (wr_sel),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .grp_start    (grp_start),
    .grp_busy     (grp_busy),
    .grp_done     (grp_done)
);

// File: tb/sim_vrf_multiview.sv
`timescale 1ns/1ps
// Bench sim_vrf_multiview: sweeps registers, views, arrangements and lanes,
// and runs group transfers, against a shadow model built from the requirements.
module sim_vrf_multiview;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   rd0_idx = '0, rd1_idx = '0;
    logic [1:0]   rd0_kind = '0, rd1_kind = '0;
    logic [2:0]   rd0_sel = '0, rd1_sel = '0;
    logic [3:0]   rd0_lane = '0, rd1_lane = '0;
    logic [127:0] rd0_data, rd1_data;
    logic         rd0_lane_err, rd1_lane_err;
    logic         wr_en = 1'b0, wr_kind = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [4:0]   wr_idx = '0;
    logic [127:0] wr_data = '0;
    logic         grp_start = 1'b0, grp_write = 1'b0;
    logic [4:0]   grp_first = '0;
    logic [1:0]   grp_count = '0;
    logic [127:0] grp_wdata = '0, grp_rdata;
    logic         grp_busy, grp_done;

    logic [127:0] model [32];
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vrf_multiview u0 (.*);

    function automatic logic [127:0] pat(input int r, input int salt);
        logic [127:0] v;
        for (int b = 0; b < 16; b++) v[b*8 +: 8] = 8'((r * 16 + b) * 7 + salt * 13 + 1);
        return v;
    endfunction

    function automatic int vw(input logic [2:0] sel);
        return (sel < 3'd4) ? (8 << sel) : 128;
    endfunction

    function automatic logic [127:0] lowmask(input int w);
        return (w >= 128) ? {128{1'b1}} : ((128'd1 << w) - 128'd1);
    endfunction

    // Expected read result computed from R2, R4, R5, R6.
    function automatic logic [127:0] exp_rd(input logic [1:0] kind, input logic [2:0] sel,
                                           input logic [3:0] lane, input logic [127:0] v,
                                           output logic err);
        int w;
        err = 1'b0;
        if (kind[1]) begin
            w = vw(sel);
            if (int'(lane) >= 128 / w) begin
                err = 1'b1;
                return '0;
            end
            return (v >> (int'(lane) * w)) & lowmask(w);
        end else if (kind[0]) begin
            return sel[2] ? (v & lowmask(64)) : v;
        end
        return v & lowmask(vw(sel));
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive both read ports with the same access and check against the model.
    task automatic probe(input int i0, input int i1, input logic [1:0] kind,
                         input logic [2:0] sel, input logic [3:0] lane, input string req);
        logic e0, e1;
        logic [127:0] x0, x1;
        rd0_idx = 5'(i0); rd1_idx = 5'(i1);
        rd0_kind = kind; rd1_kind = kind;
        rd0_sel = sel; rd1_sel = sel;
        rd0_lane = lane; rd1_lane = lane;
        #0.5;
        x0 = exp_rd(kind, sel, lane, model[i0], e0);
        x1 = exp_rd(kind, sel, lane, model[i1], e1);
        chk(req, rd0_data, x0);
        chk(req, rd1_data, x1);
        chk({req, " lane_err"}, {127'd0, rd0_lane_err}, {127'd0, e0});
        chk({req, " lane_err"}, {127'd0, rd1_lane_err}, {127'd0, e1});
    endtask

    task automatic wport(input logic kind, input logic [2:0] sel, input int idx,
                         input logic [127:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_sel = sel; wr_idx = 5'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (kind) model[idx] = sel[2] ? (d & lowmask(64)) : d;
        else      model[idx] = d & lowmask(vw(sel));
    endtask

    // Run one group transfer, checking busy/done timing, wrap and data (R9-R11, R13).
    task automatic grp_run(input bit wm, input int first, input int n, input int salt,
                           input bit poke);
        @(negedge clk);
        grp_start = 1'b1; grp_write = wm; grp_first = 5'(first); grp_count = 2'(n - 1);
        @(negedge clk);
        grp_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            int r;
            r = (first + i) % 32;
            chk("R9 busy during beat", {127'd0, grp_busy}, 128'd1);
            if (wm) begin
                grp_wdata = pat(r, salt);
                chk("R13 rdata zero in write beat", grp_rdata, '0);
            end else begin
                chk("R10 group read wrap order", grp_rdata, model[r]);
            end
            if (poke && i == 0) begin
                grp_start = 1'b1; grp_first = 5'((first + 9) % 32); grp_count = 2'd3;
                grp_write = ~wm;
            end
            @(negedge clk);
            grp_start = 1'b0; grp_write = wm;
            if (wm) model[r] = pat(r, salt);
        end
        chk("R11 busy low after last", {127'd0, grp_busy}, 128'd0);
        chk("R11 done pulse", {127'd0, grp_done}, 128'd1);
        @(negedge clk);
        chk("R11 done one cycle", {127'd0, grp_done}, 128'd0);
        chk("R11 start while busy ignored", {127'd0, grp_busy}, 128'd0);
        chk("R13 rdata zero when idle", grp_rdata, '0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 32; r++) model[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int r = 0; r < 32; r++) probe(r, 31 - r, 2'd0, 3'd4, 4'd0, "R1 reset clear");
        chk("R1 busy idle", {126'd0, grp_busy, grp_done}, '0);

        // Fill all registers with full-width vector writes.
        for (int r = 0; r < 32; r++) wport(1'b1, 3'd0, r, pat(r, 1));

        // R2, R4, R5, R6, R7: sweep every register with every access form.
        for (int r = 0; r < 32; r++) begin
            for (int s = 0; s < 8; s++) begin
                probe(r, (r + 5) % 32, 2'd0, 3'(s), 4'd0, "R2 scalar view");
                probe(r, (r + 5) % 32, 2'd1, 3'(s), 4'd0, "R4 arrangement read");
            end
            for (int s = 0; s < 5; s++)
                for (int l = 0; l < 16; l++)
                    probe(r, (r + 11) % 32, 2'd2, 3'(s), 4'(l), "R5 R6 element read");
        end
        probe(9, 9, 2'd0, 3'd4, 4'd0, "R7 same register both ports");
        probe(9, 9, 2'd3, 3'd1, 4'd6, "R7 R5 lane 6 half-word");
        chk("R5 lane 6 of 16 bits", rd0_data, {112'd0, model[9][111:96]});

        // R3, R4: shaped writes into a register holding all ones.
        for (int s = 0; s < 8; s++) begin
            wport(1'b1, 3'd0, 3, {128{1'b1}});
            wport(1'b0, 3'(s), 3, pat(3, s + 20));
            probe(3, 3, 2'd0, 3'd4, 4'd0, "R3 scalar write clears upper");
            wport(1'b1, 3'd0, 4, {128{1'b1}});
            wport(1'b1, 3'(s), 4, pat(4, s + 40));
            probe(4, 4, 2'd0, 3'd4, 4'd0, "R4 arrangement write");
        end

        // R8: read during write sees old contents, then the new value.
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 1'b1; wr_sel = 3'd0; wr_idx = 5'd7; wr_data = pat(7, 99);
        rd0_idx = 5'd7; rd0_kind = 2'd0; rd0_sel = 3'd4;
        #0.5;
        chk("R8 old contents same cycle", rd0_data, model[7]);
        @(negedge clk);
        wr_en = 1'b0;
        model[7] = pat(7, 99);
        #0.5;
        chk("R8 new value next cycle", rd0_data, model[7]);

        // R9, R10, R11, R13: group transfers of every length, wrapping past 31.
        for (int n = 1; n <= 4; n++) begin
            grp_run(1'b1, 29 + (n % 3), n, 50 + n, n == 2);
            grp_run(1'b0, 30, n, 0, n == 3);
        end
        for (int r = 0; r < 32; r++) probe(r, r, 2'd0, 3'd4, 4'd0, "R10 group write wrap");

        // R12: group beat collides with write port; a different target still lands.
        @(negedge clk);
        grp_start = 1'b1; grp_write = 1'b1; grp_first = 5'd31; grp_count = 2'd1;
        @(negedge clk);
        grp_start = 1'b0;
        grp_wdata = pat(31, 70);
        wr_en = 1'b1; wr_kind = 1'b1; wr_sel = 3'd0; wr_idx = 5'd31; wr_data = pat(31, 71);
        @(negedge clk);
        grp_wdata = pat(0, 70);
        wr_idx = 5'd12; wr_data = pat(12, 71);
        @(negedge clk);
        wr_en = 1'b0;
        model[31] = pat(31, 70); model[0] = pat(0, 70); model[12] = pat(12, 71);
        probe(31, 12, 2'd0, 3'd4, 4'd0, "R12 group wins, other write lands");
        probe(0, 0, 2'd0, 3'd4, 4'd0, "R12 second beat");

        // R1: reset after activity clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) model[r] = '0;
        for (int r = 0; r < 32; r++) probe(r, r, 2'd0, 3'd4, 4'd0, "R1 reset after use");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule